// File: doc/BRIEF.md
# Receive Chunk Footer Decoder and Frame Rebuilder

This block sits behind the serial-link receiver of a 10 Mb/s single-pair Ethernet MAC-PHY host interface. The link delivers fixed 68-byte chunks: 64 payload bytes, then a 4-byte trailing status word (the footer), most-significant byte first. The block writes each payload into one half of a two-bank byte buffer. When the footer is complete it decodes it, updates the transmit-credit and receive-chunk counts, raises a service request for extended status, and detects fatal link errors. It then replays the useful payload bytes from the buffer as a byte stream with valid/last framing.

One payload can hold a complete frame, the first part of a frame, a middle part, a final part, or the tail of one frame followed by the head of the next. The decoder tracks whether a frame is open on the output. A frame that cannot be finished is closed with a one-cycle abort beat. When an external receive-overflow indication arrives, the block aborts the open frame and throws away payload until a chunk that marks a frame start.

Top module: `rx_chunk_reasm`

## Requirements
- R1: The footer is taken from chunk bytes 64..67, byte 64 being bits 31:24. `tx_credits` takes footer bits 5:1 and `rx_chunks` takes bits 28:24 from every footer, whatever bit 21 holds. Both stay unchanged between footers.
- R2: Payload bytes are output only when footer bit 21 (data-valid) is 1. A chunk with bit 21 at 0 produces no beat, even if its start or end flags are set.
- R3: The start position is the 4-bit word offset in bits 19:16 times 4. The end position is the 6-bit byte offset in bits 13:8. When start-valid (bit 20) and end-valid (bit 14) are both 1 and start is at or below end, bytes start..end are output as one frame. `out_last` is 1 on the byte at end, and only on a byte beat.
- R4: With only start-valid set, bytes start..63 open a frame with no last. With neither flag set, bytes 0..63 continue the open frame. With only end-valid set, bytes 0..end close the open frame, with last on byte end.
- R5: When both flags are set and start is above end, bytes 0..end close the open frame (last on byte end), then bytes start..63 open a new frame.
- R6: An end portion or a continuation that arrives while no frame is open is dropped. A start that arrives while a frame is open first closes the old frame with an abort beat.
- R7: A pulse on `rx_overflow` takes effect at the next footer. The open frame, if any, is closed with an abort beat. Payload is then discarded until a data-valid chunk with start-valid. From that chunk, only the start portion is output.
- R8: A footer with bit 30 (header bad) at 1, or bit 29 (configuration in sync) at 0, sets `fatal_err`, which holds until reset. The open frame is closed with an abort beat. No payload is output afterwards, but the counters still update.
- R9: Footer bit 31 at 1 raises `status_req` for exactly one cycle for that chunk.
- R10: An abort beat is one cycle with `out_abort` 1 and `out_valid` 0.
- R11: After reset all outputs are 0, no frame is open and no discard is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One chunk byte is present on `in_byte` |
| in_byte | input | 8 | Chunk byte, payload first, then footer bytes MSB first |
| rx_overflow | input | 1 | One-cycle receive-overflow indication |
| out_valid | output | 1 | Output byte beat |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of a frame |
| out_abort | output | 1 | Open frame is abandoned (no data this cycle) |
| tx_credits | output | 5 | Transmit credits from the latest footer |
| rx_chunks | output | 5 | Receive chunks available from the latest footer |
| status_req | output | 1 | Extended-status service request pulse |
| fatal_err | output | 1 | Sticky fatal link error |

## Verification
Each chunk uses a distinct payload ramp, so every output byte identifies its source chunk and offset. A missing, repeated or shifted byte therefore shows up in the stream. The chunk patterns are:
- a complete frame inside one payload;
- a frame spread over start, middle and end chunks;
- an end followed by a start in the same chunk, which catches errors in segment ordering and last placement;
- orphan ends and continuations, and chunks with data-valid at 0 that still carry flags, which show whether the open-frame state gates the output;
- the overflow and fatal sequences, which check discard recovery, abort beats, and that the counters keep updating while payload is suppressed.

// File: rtl/rx_reasm_pkg.sv
package rx_reasm_pkg;

  // payload and footer sizes fixed by the chunk format
  localparam int PAY_BYTES  = 64;
  localparam int FOOT_BYTES = 4;
  localparam int IDX_W      = $clog2(PAY_BYTES);
  localparam int FOOT_W     = 8 * FOOT_BYTES;
  localparam int CNT_FLD_W  = 5;

  // footer bit positions
  localparam int FB_EXT    = 31;
  localparam int FB_HBAD   = 30;
  localparam int FB_SYNC   = 29;
  localparam int FB_RXC_LO = 24;
  localparam int FB_DV     = 21;
  localparam int FB_SV     = 20;
  localparam int FB_SW_LO  = 16;
  localparam int FB_EV     = 14;
  localparam int FB_EB_LO  = 8;
  localparam int FB_CR_LO  = 1;

  typedef struct packed {
    logic             en;
    logic             close;
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] hi;
  } seg_t;

  typedef struct packed {
    logic abort;
    logic bank;
    seg_t s0;
    seg_t s1;
  } job_t;

endpackage

// File: rtl/chunk_buffer.sv
module chunk_buffer #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/chunk_capture.sv
module chunk_capture
  import rx_reasm_pkg::*;
#(
  parameter int PAY  = PAY_BYTES,
  parameter int FOOT = FOOT_BYTES,
  localparam int CHUNK  = PAY + FOOT,
  localparam int CNT_W  = $clog2(CHUNK),
  localparam int PIDX_W = $clog2(PAY),
  localparam int ADDR_W = PIDX_W + 1,
  localparam int FW     = 8 * FOOT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              footer_stb,
  output logic [FW-1:0]     footer_word,
  output logic              footer_bank
);

  localparam logic [CNT_W-1:0] PAY_C  = CNT_W'(PAY);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CHUNK - 1);

  logic [CNT_W-1:0]  cnt;
  logic              bank;
  logic [FW-9:0]     shreg;

  assign wr_en   = in_valid && (cnt < PAY_C);
  assign wr_addr = {bank, cnt[PIDX_W-1:0]};
  assign wr_data = in_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      bank        <= 1'b0;
      shreg       <= '0;
      footer_stb  <= 1'b0;
      footer_word <= '0;
      footer_bank <= 1'b0;
    end else begin
      footer_stb <= 1'b0;
      if (in_valid) begin
        if (cnt == LAST_C) begin
          cnt         <= '0;
          footer_word <= {shreg, in_byte};
          footer_bank <= bank;
          footer_stb  <= 1'b1;
          bank        <= ~bank;
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt >= PAY_C) shreg <= {shreg[FW-17:0], in_byte};
        end
      end
    end
  end

endmodule

// File: rtl/footer_decode.sv
module footer_decode
  import rx_reasm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 footer_stb,
  input  logic [FOOT_W-1:0]    footer_word,
  input  logic                 footer_bank,
  input  logic                 rx_overflow,
  output logic                 job_stb,
  output job_t                 job,
  output logic [CNT_FLD_W-1:0] tx_credits,
  output logic [CNT_FLD_W-1:0] rx_chunks,
  output logic                 status_req,
  output logic                 fatal_err
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(PAY_BYTES - 1);

  logic             open_q, disc_q, ovf_pend;
  logic             f_ext, f_hbad, f_sync, f_dv, f_sv, f_ev;
  logic [IDX_W-1:0] f_start, f_end;
  logic             n_open, n_disc, n_fatal, n_stb;
  job_t             n_job;
  logic             unused_ftr;

  assign f_ext   = footer_word[FB_EXT];
  assign f_hbad  = footer_word[FB_HBAD];
  assign f_sync  = footer_word[FB_SYNC];
  assign f_dv    = footer_word[FB_DV];
  assign f_sv    = footer_word[FB_SV];
  assign f_ev    = footer_word[FB_EV];
  assign f_start = {footer_word[FB_SW_LO +: 4], 2'b00};
  assign f_end   = footer_word[FB_EB_LO +: IDX_W];
  assign unused_ftr = ^{footer_word[23:22], footer_word[15], footer_word[7:6],
                        footer_word[0]};

  always_comb begin
    n_job      = '0;
    n_job.bank = footer_bank;
    n_open     = open_q;
    n_disc     = disc_q;
    n_fatal    = fatal_err;
    if (fatal_err) begin
      n_open = 1'b0;
    end else if (f_hbad || !f_sync) begin
      n_fatal     = 1'b1;
      n_job.abort = open_q;
      n_open      = 1'b0;
    end else begin
      if (ovf_pend) begin
        n_job.abort = open_q;
        n_open      = 1'b0;
        n_disc      = 1'b1;
      end
      if (f_dv) begin
        if (f_sv) n_disc = 1'b0;
        if (!n_disc) begin
          if (f_sv && f_ev && (f_start <= f_end)) begin
            if (n_open) n_job.abort = 1'b1;
            n_job.s0 = '{en: 1'b1, close: 1'b1, lo: f_start, hi: f_end};
            n_open   = 1'b0;
          end else if (f_sv && f_ev) begin
            if (n_open) begin
              n_job.s0 = '{en: 1'b1, close: 1'b1, lo: '0, hi: f_end};
              n_job.s1 = '{en: 1'b1, close: 1'b0, lo: f_start, hi: TOP_IDX};
            end else begin
              n_job.s0 = '{en: 1'b1, close: 1'b0, lo: f_start, hi: TOP_IDX};
            end
            n_open = 1'b1;
          end else if (f_sv) begin
            if (n_open) n_job.abort = 1'b1;
            n_job.s0 = '{en: 1'b1, close: 1'b0, lo: f_start, hi: TOP_IDX};
            n_open   = 1'b1;
          end else if (f_ev) begin
            if (n_open) begin
              n_job.s0 = '{en: 1'b1, close: 1'b1, lo: '0, hi: f_end};
              n_open   = 1'b0;
            end
          end else if (n_open) begin
            n_job.s0 = '{en: 1'b1, close: 1'b0, lo: '0, hi: TOP_IDX};
          end
        end
      end
    end
    n_stb = n_job.abort || n_job.s0.en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q     <= 1'b0;
      disc_q     <= 1'b0;
      ovf_pend   <= 1'b0;
      fatal_err  <= 1'b0;
      tx_credits <= '0;
      rx_chunks  <= '0;
      status_req <= 1'b0;
      job_stb    <= 1'b0;
      job        <= '0;
    end else begin
      status_req <= 1'b0;
      job_stb    <= 1'b0;
      if (footer_stb) begin
        tx_credits <= footer_word[FB_CR_LO +: CNT_FLD_W];
        rx_chunks  <= footer_word[FB_RXC_LO +: CNT_FLD_W];
        status_req <= f_ext;
        open_q     <= n_open;
        disc_q     <= n_disc;
        fatal_err  <= n_fatal;
        job_stb    <= n_stb;
        job        <= n_job;
        ovf_pend   <= rx_overflow;
      end else if (rx_overflow) begin
        ovf_pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/payload_replay.sv
module payload_replay
  import rx_reasm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               job_stb,
  input  job_t               job,
  output logic               rd_en,
  output logic [IDX_W:0]     rd_addr,
  output logic               out_valid,
  output logic               out_last,
  output logic               out_abort
);

  job_t             cur;
  logic [IDX_W-1:0] idx;
  logic             em_valid, em_last, em_abort;
  logic [IDX_W-1:0] cur_hi;
  logic             cur_close;

  always_comb begin
    cur_hi    = cur.s0.en ? cur.s0.hi : cur.s1.hi;
    cur_close = cur.s0.en ? cur.s0.close : cur.s1.close;
    em_abort  = cur.abort;
    em_valid  = !cur.abort && (cur.s0.en || cur.s1.en);
    em_last   = em_valid && cur_close && (idx == cur_hi);
  end

  assign rd_en   = em_valid;
  assign rd_addr = {cur.bank, idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_abort <= 1'b0;
    end else begin
      out_valid <= em_valid;
      out_last  <= em_last;
      out_abort <= em_abort;
      if (job_stb) begin
        cur <= job;
        idx <= job.s0.lo;
      end else if (cur.abort) begin
        cur.abort <= 1'b0;
      end else if (cur.s0.en) begin
        if (idx == cur.s0.hi) begin
          cur.s0.en <= 1'b0;
          idx       <= cur.s1.lo;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (cur.s1.en) begin
        if (idx == cur.s1.hi) cur.s1.en <= 1'b0;
        else                  idx <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_chunk_reasm.sv
module rx_chunk_reasm
  import rx_reasm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [7:0]           in_byte,
  input  logic                 rx_overflow,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 out_last,
  output logic                 out_abort,
  output logic [CNT_FLD_W-1:0] tx_credits,
  output logic [CNT_FLD_W-1:0] rx_chunks,
  output logic                 status_req,
  output logic                 fatal_err
);

  localparam int BUF_DEPTH = 2 * PAY_BYTES;
  localparam int ADDR_W    = IDX_W + 1;

  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data;
  logic              footer_stb, footer_bank;
  logic [FOOT_W-1:0] footer_word;
  logic              job_stb;
  job_t              job;

  chunk_capture #(.PAY(PAY_BYTES), .FOOT(FOOT_BYTES)) u_capture (
    .clk, .rst, .in_valid, .in_byte,
    .wr_en, .wr_addr, .wr_data,
    .footer_stb, .footer_word, .footer_bank
  );

  chunk_buffer #(.DEPTH(BUF_DEPTH), .DATA_W(8)) u_buffer (
    .clk, .wr_en, .wr_addr, .wr_data,
    .rd_en, .rd_addr, .rd_data(out_data)
  );

  footer_decode u_decode (
    .clk, .rst, .footer_stb, .footer_word, .footer_bank, .rx_overflow,
    .job_stb, .job, .tx_credits, .rx_chunks, .status_req, .fatal_err
  );

  payload_replay u_replay (
    .clk, .rst, .job_stb, .job,
    .rd_en, .rd_addr, .out_valid, .out_last, .out_abort
  );

endmodule

// File: rtl/rx_chunk_reasm_chk.sv
module rx_chunk_reasm_chk (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic       out_last,
  input logic       out_abort,
  input logic       status_req,
  input logic       fatal_err,
  input logic       footer_stb,
  input logic [4:0] tx_credits,
  input logic [4:0] rx_chunks
);

  // R10
  abort_alone_chk: assert property (@(posedge clk) disable iff (rst)
    out_abort |-> !out_valid);

  // R3
  last_on_beat_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R8
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fatal_err |=> fatal_err);

  // R8
  fatal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fatal_err) |-> !out_valid);

  // R9
  status_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    status_req |=> !status_req);

  // R1
  credit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(footer_stb) |-> ($stable(tx_credits) && $stable(rx_chunks)));

endmodule

bind rx_chunk_reasm rx_chunk_reasm_chk u_reasm_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_last(out_last),
  .out_abort(out_abort), .status_req(status_req), .fatal_err(fatal_err),
  .footer_stb(footer_stb), .tx_credits(tx_credits), .rx_chunks(rx_chunks)
);

// File: tb/test_rx_chunk_reasm.sv
module test_rx_chunk_reasm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       rx_overflow = 1'b0;
  logic       out_valid, out_last, out_abort, status_req, fatal_err;
  logic [7:0] out_data;
  logic [4:0] tx_credits, rx_chunks;

  int checks = 0;
  int errors = 0;
  int req_pulses = 0;
  bit done = 0;
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];

  always #5 clk = ~clk;

  rx_chunk_reasm i_rx_chunk_reasm (
    .clk, .rst, .in_valid, .in_byte, .rx_overflow,
    .out_valid, .out_data, .out_last, .out_abort,
    .tx_credits, .rx_chunks, .status_req, .fatal_err
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_abort)      got_q.push_back(10'h200);
      else if (out_valid) got_q.push_back({1'b0, out_last, out_data});
      if (status_req)     req_pulses++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ftr(bit ext, bit hbad, bit sync, int rxc,
      bit dv, bit sv, int sw, bit ev, int eb, int cr);
    logic [31:0] f = '0;
    f[31] = ext; f[30] = hbad; f[29] = sync; f[28:24] = rxc[4:0];
    f[21] = dv; f[20] = sv; f[19:16] = sw[3:0]; f[14] = ev;
    f[13:8] = eb[5:0]; f[5:1] = cr[4:0];
    return f;
  endfunction

  task automatic send_chunk(logic [7:0] seed, logic [31:0] f);
    for (int i = 0; i < 68; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_byte  = (i < 64) ? seed + 8'(i) : f[8*(67-i) +: 8];
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    repeat (80) @(posedge clk);
    #1;
  endtask

  task automatic exp_range(logic [7:0] seed, int lo, int hi, bit close);
    for (int i = lo; i <= hi; i++)
      exp_q.push_back({1'b0, close && (i == hi), seed + 8'(i)});
  endtask

  task automatic exp_abort();
    exp_q.push_back(10'h200);
  endtask

  task automatic cmp_stream(string req);
    int bad = -1;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    if (got_q.size() != exp_q.size())
      check(0, req, "stream length", got_q.size(), exp_q.size());
    else if (bad >= 0)
      check(0, req, $sformatf("beat %0d {abort,last,data}", bad),
            int'(got_q[bad]), int'(exp_q[bad]));
    else
      check(1, req, "stream", 0, 0);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    // R11
    check(out_valid == 0 && out_abort == 0 && out_last == 0, "R11",
          "framing outputs", {out_valid, out_abort, out_last}, 0);
    check(tx_credits == 0 && rx_chunks == 0, "R11", "counters",
          {tx_credits, rx_chunks}, 0);
    check(status_req == 0 && fatal_err == 0, "R11", "flags",
          {status_req, fatal_err}, 0);
  endtask

  task automatic t_whole();
    // R3 whole frame bytes 8..20, R1 counters
    send_chunk(8'h10, ftr(0, 0, 1, 3, 1, 1, 2, 1, 20, 7));
    settle();
    exp_range(8'h10, 8, 20, 1);
    cmp_stream("R3");
    check(tx_credits == 7, "R1", "tx_credits", tx_credits, 7);
    check(rx_chunks == 3, "R1", "rx_chunks", rx_chunks, 3);
  endtask

  task automatic t_span();
    // R4 start / middle / end chunks
    send_chunk(8'd40, ftr(0, 0, 1, 2, 1, 1, 1, 0, 0, 4));
    send_chunk(8'd80, ftr(0, 0, 1, 1, 1, 0, 0, 0, 0, 4));
    send_chunk(8'd120, ftr(0, 0, 1, 0, 1, 0, 0, 1, 9, 4));
    settle();
    exp_range(8'd40, 4, 63, 0);
    exp_range(8'd80, 0, 63, 0);
    exp_range(8'd120, 0, 9, 1);
    cmp_stream("R4");
  endtask

  task automatic t_endstart();
    // R5 end then start inside one payload
    send_chunk(8'd1, ftr(0, 0, 1, 0, 1, 1, 15, 0, 0, 1));
    send_chunk(8'd50, ftr(0, 0, 1, 0, 1, 1, 8, 1, 5, 1));
    send_chunk(8'd9, ftr(0, 0, 1, 0, 1, 0, 0, 1, 3, 1));
    settle();
    exp_range(8'd1, 60, 63, 0);
    exp_range(8'd50, 0, 5, 1);
    exp_range(8'd50, 32, 63, 0);
    exp_range(8'd9, 0, 3, 1);
    cmp_stream("R5");
  endtask

  task automatic t_nodata();
    // R2 data-valid clear: no beats, R1 counters still follow
    send_chunk(8'd70, ftr(0, 0, 1, 9, 0, 1, 0, 1, 30, 17));
    settle();
    cmp_stream("R2");
    check(tx_credits == 17, "R1", "tx_credits on empty chunk", tx_credits, 17);
    check(rx_chunks == 9, "R1", "rx_chunks on empty chunk", rx_chunks, 9);
    // R6 orphan end and orphan continuation are dropped
    send_chunk(8'd90, ftr(0, 0, 1, 0, 1, 0, 0, 1, 10, 2));
    send_chunk(8'd95, ftr(0, 0, 1, 0, 1, 0, 0, 0, 0, 2));
    settle();
    cmp_stream("R6");
  endtask

  task automatic t_restart();
    // R6 start while open aborts the old frame first
    send_chunk(8'd3, ftr(0, 0, 1, 0, 1, 1, 0, 0, 0, 2));
    send_chunk(8'd33, ftr(0, 0, 1, 0, 1, 1, 4, 1, 30, 2));
    settle();
    exp_range(8'd3, 0, 63, 0);
    exp_abort();
    exp_range(8'd33, 16, 30, 1);
    cmp_stream("R6");
  endtask

  task automatic t_overflow();
    // R7 discard until start, R10 abort beat
    send_chunk(8'd5, ftr(0, 0, 1, 0, 1, 1, 0, 0, 0, 2));
    settle();
    exp_range(8'd5, 0, 63, 0);
    cmp_stream("R7");
    @(posedge clk); #1;
    rx_overflow = 1'b1;
    @(posedge clk); #1;
    rx_overflow = 1'b0;
    send_chunk(8'd60, ftr(0, 0, 1, 0, 1, 0, 0, 0, 0, 2));
    settle();
    exp_abort();
    cmp_stream("R10");
    send_chunk(8'd66, ftr(0, 0, 1, 0, 1, 0, 0, 1, 20, 2));
    send_chunk(8'd77, ftr(0, 0, 1, 0, 1, 1, 12, 1, 7, 2));
    send_chunk(8'd88, ftr(0, 0, 1, 0, 1, 0, 0, 1, 2, 2));
    settle();
    exp_range(8'd77, 48, 63, 0);
    exp_range(8'd88, 0, 2, 1);
    cmp_stream("R7");
  endtask

  task automatic t_ext();
    // R9 one pulse per flagged chunk
    req_pulses = 0;
    send_chunk(8'd0, ftr(1, 0, 1, 0, 0, 0, 0, 0, 0, 3));
    send_chunk(8'd0, ftr(0, 0, 1, 0, 0, 0, 0, 0, 0, 3));
    settle();
    check(req_pulses == 1, "R9", "status_req pulses", req_pulses, 1);
    cmp_stream("R9");
  endtask

  task automatic t_fatal_hdr();
    // R8 header-bad: abort, sticky, counters still update
    send_chunk(8'd11, ftr(0, 0, 1, 0, 1, 1, 0, 0, 0, 2));
    send_chunk(8'd22, ftr(0, 1, 1, 0, 1, 1, 0, 1, 9, 2));
    send_chunk(8'd44, ftr(0, 0, 1, 6, 1, 1, 0, 1, 9, 11));
    settle();
    exp_range(8'd11, 0, 63, 0);
    exp_abort();
    cmp_stream("R8");
    check(fatal_err == 1, "R8", "fatal_err after header bad", fatal_err, 1);
    check(tx_credits == 11, "R8", "tx_credits after fatal", tx_credits, 11);
    do_reset();
    check(fatal_err == 0, "R11", "fatal_err cleared by reset", fatal_err, 0);
  endtask

  task automatic t_fatal_sync();
    // R8 sync lost: no output for the frame in that chunk
    send_chunk(8'd55, ftr(0, 0, 0, 0, 1, 1, 0, 1, 9, 1));
    settle();
    cmp_stream("R8");
    check(fatal_err == 1, "R8", "fatal_err after sync lost", fatal_err, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", "cycles run", 100000, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_whole();
    t_span();
    t_endstart();
    t_nodata();
    t_restart();
    do_reset();
    t_overflow();
    do_reset();
    t_ext();
    t_fatal_hdr();
    t_fatal_sync();
    finish_run();
  end

endmodule